// File: doc/BRIEF.md
# Capture/Compare Event Timer with One-Shot Output

A 16-bit up-counter advances on a count tick. The tick comes from the system clock divided by 1, 2, 4 or 8. It can instead come from valid edges seen on trigger input 0. Software sets up the block over a small register bus: one control word, two capture/compare registers, a counter that can only be read, and a status word. The status word holds the overflow flag and is also where a one-shot is started. The block has two interrupt request outputs, a sticky overflow flag and a timer output pin.

Each capture/compare register works either as a compare value or as a capture target. CR0 captures on a valid edge of trigger input 1, and CR1 captures on a valid edge of trigger input 0. A two-sample filter qualifies both trigger inputs. The counter can run free, restart after a match with CR0, or restart on a valid edge of trigger input 0. A one-shot pulse is raised at a match with CR1 and dropped at a match with CR0.

Top module: `evtimer`

## Requirements
- R1: While the run bit (ctrl bit 0) is 0, the counter reads 0 and the timer output is low. Trigger edges cause no capture and no interrupt, and a one-shot request has no effect.
- R2: With ctrl bit 5 at 0, a count tick occurs every 2^s system clocks, where s is ctrl bits 4:3. With ctrl bit 5 at 1, a count tick occurs once per valid filtered edge of trigger input 0. The counter changes only on a tick.
- R3: A tick at 0xFFFF that is not a clear wraps the counter to 0 and sets the overflow flag (status bit 0). The flag stays set until software writes 1 to status bit 0.
- R4: A tick while the counter equals CR0 pulses irq0 for one cycle, provided CR0 is in compare mode. The same holds for CR1 and irq1.
- R5: In clear-on-match mode (ctrl bits 2:1 = 1), a tick while the counter equals CR0 loads 0 in place of the increment. irq0 therefore repeats every (CR0+1) ticks.
- R6: In clear-on-edge mode (ctrl bits 2:1 = 2), a valid edge of trigger input 0 makes the next tick load 0 into the counter.
- R7: Edge select uses 0 for none, 1 for rising, 2 for falling and 3 for both. Trigger input 1 uses ctrl bits 9:8 and trigger input 0 uses ctrl bits 7:6. When ctrl bit 10 is set, a valid edge of trigger input 1 copies the counter into CR0. When ctrl bit 11 is set, a valid edge of trigger input 0 copies the counter into CR1.
- R8: Reading the counter (address 3) never changes CR0 or CR1.
- R9: Capture into CR1 from trigger input 0 is suppressed in two cases: when ticks come from that input (ctrl bit 5 = 1), and when its edge select is "both".
- R10: A trigger level change counts only after it has been seen on two consecutive prescaler samples. A pulse shorter than one sample period is ignored.
- R11: The interrupt for a capture is raised for one cycle on the first tick after the capture cycle.
- R12: Writing 1 to status bit 1 arms a one-shot. The timer output goes high on a tick where the counter equals CR1 and goes low on a tick where it equals CR0. A second request while the one-shot is armed is ignored.
- R13: In clear-on-match mode, a one-shot request is ignored and the timer output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address: 0 ctrl, 1 CR0, 2 CR1, 3 counter, 4 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| trig0 | input | 1 | Trigger input 0 (capture into CR1, external count, clear) |
| trig1 | input | 1 | Trigger input 1 (capture into CR0) |
| irq0 | output | 1 | Interrupt request 0 (CR0 match or capture) |
| irq1 | output | 1 | Interrupt request 1 (CR1 match or capture) |
| ovf_flag | output | 1 | Sticky overflow flag |
| tmr_out | output | 1 | One-shot timer output |

## Verification
The hardest case to reach is a retriggered one-shot that wrongly stays armed. The error only shows after a full 65536-tick wrap, when the counter returns to CR1. The stimulus sends a second one-shot request while the pulse is high, then keeps the counter running at divide-by-1 through a whole wrap. Over that window the timer output must stay low and the overflow flag must set. The capture-to-interrupt delay is measured cycle by cycle at divide-by-4. Glitch rejection uses pulses that are provably shorter and longer than the sample period at divide-by-8.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int NTRIG  = 2;
    localparam int CTRL_W = 12;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_CR0  = 3'd1;
    localparam logic [2:0] ADDR_CR1  = 3'd2;
    localparam logic [2:0] ADDR_CNT  = 3'd3;
    localparam logic [2:0] ADDR_STAT = 3'd4;

    typedef enum logic [1:0] {
        MODE_FREE      = 2'd0,
        MODE_CLR_MATCH = 2'd1,
        MODE_CLR_EDGE  = 2'd2,
        MODE_RSVD      = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } esel_e;

    // bit 11 .. bit 0
    typedef struct packed {
        logic       cap1;   // CR1 captures on trigger 0
        logic       cap0;   // CR0 captures on trigger 1
        esel_e      esel1;
        esel_e      esel0;
        logic       ext;    // count on trigger 0 edges
        logic [1:0] div;
        mode_e      mode;
        logic       run;
    } ctrl_t;

endpackage

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             strobe
);
    localparam int PW = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          strobe;
    } pre_t;

    pre_t st_d, st_q;
    logic [PW-1:0] mask;

    always_comb begin
        st_d = st_q;
        mask = ~({PW{1'b1}} << div_sel);
        if (!run) begin
            st_d.cnt    = '0;
            st_d.strobe = 1'b0;
        end else begin
            st_d.strobe = ((st_q.cnt & mask) == mask);
            st_d.cnt    = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = st_q.strobe;
endmodule

// File: rtl/evt_trig_filter.sv
module evt_trig_filter
    import evt_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  strobe,
    input  logic  pin,
    input  esel_e esel,
    output logic  valid_edge
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              prev;
        logic              level;
        logic              edge_hit;
    } flt_t;

    flt_t st_d, st_q;
    logic smp;

    always_comb begin
        st_d          = st_q;
        st_d.sync     = {st_q.sync[SYNC_N-2:0], pin};
        st_d.edge_hit = 1'b0;
        smp           = st_q.sync[SYNC_N-1];
        if (!run) begin
            // track the pin so a start produces no false edge
            st_d.level = smp;
            st_d.prev  = smp;
        end else if (strobe) begin
            st_d.prev = smp;
            if ((smp != st_q.level) && (st_q.prev == smp)) begin
                st_d.level = smp;
                unique case (esel)
                    EDGE_RISE: st_d.edge_hit = smp;
                    EDGE_FALL: st_d.edge_hit = !smp;
                    EDGE_BOTH: st_d.edge_hit = 1'b1;
                    default:   st_d.edge_hit = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_edge = st_q.edge_hit;
endmodule

// File: rtl/evt_core.sv
module evt_core
    import evt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  mode_e        mode,
    input  logic         ext,
    input  esel_e        esel0,
    input  logic         cap0,
    input  logic         cap1,
    input  logic         tick,
    input  logic         edge0,
    input  logic         edge1,
    input  logic         wr_cr0,
    input  logic         wr_cr1,
    input  logic [W-1:0] wdata,
    input  logic         clr_ovf,
    input  logic         os_start,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cr0,
    output logic [W-1:0] cr1,
    output logic         ovf,
    output logic         irq0,
    output logic         irq1,
    output logic         tmr_out
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cr0;
        logic [W-1:0] cr1;
        logic         ovf;
        logic         pend_c0;
        logic         pend_c1;
        logic         pend_clr;
        logic         armed;
        logic         out;
        logic         irq0;
        logic         irq1;
    } core_t;

    core_t st_d, st_q;
    logic  eq0, eq1, match0, match1, cap0_ok, cap1_ok;

    always_comb begin
        st_d      = st_q;
        st_d.irq0 = 1'b0;
        st_d.irq1 = 1'b0;
        eq0       = (st_q.cnt == st_q.cr0);
        eq1       = (st_q.cnt == st_q.cr1);
        match0    = eq0 && !cap0;
        match1    = eq1 && !cap1;
        cap0_ok   = run && cap0 && edge1;
        cap1_ok   = run && cap1 && edge0 && !ext && (esel0 != EDGE_BOTH);

        if (wr_cr0)  st_d.cr0 = wdata;
        if (wr_cr1)  st_d.cr1 = wdata;
        if (clr_ovf) st_d.ovf = 1'b0;

        if (!run) begin
            st_d.cnt      = '0;
            st_d.pend_c0  = 1'b0;
            st_d.pend_c1  = 1'b0;
            st_d.pend_clr = 1'b0;
            st_d.armed    = 1'b0;
            st_d.out      = 1'b0;
        end else begin
            if (tick) begin
                if (st_q.pend_c0 || match0) st_d.irq0 = 1'b1;
                if (st_q.pend_c1 || match1) st_d.irq1 = 1'b1;
                st_d.pend_c0 = 1'b0;
                st_d.pend_c1 = 1'b0;
                if (st_q.pend_clr || ((mode == MODE_CLR_MATCH) && match0)) begin
                    st_d.cnt      = '0;
                    st_d.pend_clr = 1'b0;
                end else if (st_q.cnt == {W{1'b1}}) begin
                    st_d.cnt = '0;
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                if (st_q.armed) begin
                    if (!st_q.out && eq1) begin
                        st_d.out = 1'b1;
                    end else if (st_q.out && eq0) begin
                        st_d.out   = 1'b0;
                        st_d.armed = 1'b0;
                    end
                end
            end
            // events of this cycle take effect after the tick handling
            if (cap0_ok) begin
                st_d.cr0     = st_q.cnt;
                st_d.pend_c0 = 1'b1;
            end
            if (cap1_ok) begin
                st_d.cr1     = st_q.cnt;
                st_d.pend_c1 = 1'b1;
            end
            if ((mode == MODE_CLR_EDGE) && edge0) st_d.pend_clr = 1'b1;
            if (os_start && !st_q.armed) st_d.armed = 1'b1;
            if (mode == MODE_CLR_MATCH) begin
                st_d.armed = 1'b0;
                st_d.out   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign cr0     = st_q.cr0;
    assign cr1     = st_q.cr1;
    assign ovf     = st_q.ovf;
    assign irq0    = st_q.irq0;
    assign irq1    = st_q.irq1;
    assign tmr_out = st_q.out;
endmodule

// File: rtl/evtimer.sv
module evtimer
    import evt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              trig0,
    input  logic              trig1,
    output logic              irq0,
    output logic              irq1,
    output logic              ovf_flag,
    output logic              tmr_out
);
    typedef struct packed {
        ctrl_t ctrl;
    } top_t;

    top_t              st_d, st_q;
    ctrl_t             ctrl;
    logic              strobe, tick, clr_ovf, os_start;
    logic [NTRIG-1:0]  pins, edges;
    esel_e             esels [NTRIG];
    logic [DATA_W-1:0] cnt, cr0, cr1;

    always_comb begin
        st_d = st_q;
        if (wr_en && (addr == ADDR_CTRL)) st_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl     = st_q.ctrl;
    assign clr_ovf  = wr_en && (addr == ADDR_STAT) && wdata[0];
    assign os_start = wr_en && (addr == ADDR_STAT) && wdata[1];
    assign pins     = {trig1, trig0};
    assign esels[0] = ctrl.esel0;
    assign esels[1] = ctrl.esel1;

    evt_prescaler #(.SEL_W(2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .div_sel (ctrl.div),
        .strobe  (strobe)
    );

    for (genvar g = 0; g < NTRIG; g++) begin : g_trig
        evt_trig_filter #(.SYNC_N(SYNC_N)) u_flt (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (ctrl.run),
            .strobe     (strobe),
            .pin        (pins[g]),
            .esel       (esels[g]),
            .valid_edge (edges[g])
        );
    end

    assign tick = ctrl.ext ? edges[0] : strobe;

    evt_core #(.W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl.run),
        .mode     (ctrl.mode),
        .ext      (ctrl.ext),
        .esel0    (ctrl.esel0),
        .cap0     (ctrl.cap0),
        .cap1     (ctrl.cap1),
        .tick     (tick),
        .edge0    (edges[0]),
        .edge1    (edges[1]),
        .wr_cr0   (wr_en && (addr == ADDR_CR0)),
        .wr_cr1   (wr_en && (addr == ADDR_CR1)),
        .wdata    (wdata),
        .clr_ovf  (clr_ovf),
        .os_start (os_start),
        .cnt      (cnt),
        .cr0      (cr0),
        .cr1      (cr1),
        .ovf      (ovf_flag),
        .irq0     (irq0),
        .irq1     (irq1),
        .tmr_out  (tmr_out)
    );

    always_comb begin
        unique case (addr)
            ADDR_CTRL: rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
            ADDR_CR0:  rdata = cr0;
            ADDR_CR1:  rdata = cr1;
            ADDR_CNT:  rdata = cnt;
            ADDR_STAT: rdata = {{(DATA_W-1){1'b0}}, ovf_flag};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_checker.sv
module evt_checker
    import evt_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic [1:0]   mode,
    input logic         ext,
    input logic [1:0]   esel0,
    input logic         wr_en,
    input logic [2:0]   addr,
    input logic         clr_ovf,
    input logic         tick,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cr0,
    input logic [W-1:0] cr1,
    input logic         ovf,
    input logic         irq0,
    input logic         irq1,
    input logic         tmr_out
);
    a_r1_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0) && !tmr_out);

    a_r1_stop_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && ((addr == ADDR_CR0) || (addr == ADDR_CR1))))
        |=> ($stable(cr0) && $stable(cr1)));

    a_r2_count_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt));

    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);

    a_r9_trig0_capture_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ((ext || (esel0 == EDGE_BOTH)) && !(wr_en && (addr == ADDR_CR1)))
        |=> $stable(cr1));

    a_r11_irq0_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 |-> $past(tick));

    a_r11_irq1_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq1 |-> $past(tick));

    a_r13_no_oneshot_clr_match: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CLR_MATCH) |=> !tmr_out);
endmodule

bind evtimer evt_checker #(.W(DATA_W)) i_evt_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.run),
    .mode    (ctrl.mode),
    .ext     (ctrl.ext),
    .esel0   (ctrl.esel0),
    .wr_en   (wr_en),
    .addr    (addr),
    .clr_ovf (clr_ovf),
    .tick    (tick),
    .cnt     (cnt),
    .cr0     (cr0),
    .cr1     (cr1),
    .ovf     (ovf_flag),
    .irq0    (irq0),
    .irq1    (irq1),
    .tmr_out (tmr_out)
);

// File: tb/test_evtimer.sv
`timescale 1ns/1ps
module test_evtimer;
    localparam logic [2:0] A_CTRL = 3'd0, A_CR0 = 3'd1, A_CR1 = 3'd2, A_CNT = 3'd3, A_STAT = 3'd4;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, trig0 = 1'b0, trig1 = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0, rdata;
    logic irq0, irq1, ovf_flag, tmr_out;
    int checks = 0, failures = 0, n_irq0 = 0, n_irq1 = 0;
    bit done = 1'b0;

    evtimer i_evtimer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .trig0(trig0), .trig1(trig1), .irq0(irq0), .irq1(irq1),
        .ovf_flag(ovf_flag), .tmr_out(tmr_out));

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (irq0) n_irq0++;
        if (irq1) n_irq1++;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk); addr = a; #1; v = int'(rdata);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] mk(input bit run, input int mode, input int div, input bit ext,
                                       input int es0, input int es1, input bit c0, input bit c1);
        logic [15:0] v;
        v = '0;
        v[0] = run; v[2:1] = 2'(mode); v[4:3] = 2'(div); v[5] = ext;
        v[7:6] = 2'(es0); v[9:8] = 2'(es1); v[10] = c0; v[11] = c1;
        return v;
    endfunction

    function automatic int exp_period(input int c, input int s);
        return (c + 1) * (1 << s);
    endfunction

    task automatic cfg(input logic [15:0] v);
        wr(A_CTRL, 16'd0);
        wr(A_CTRL, v);
    endtask

    task automatic pulse(input bit which, input int len);
        @(negedge clk);
        if (which) trig1 = 1'b1; else trig0 = 1'b1;
        cyc(len);
        if (which) trig1 = 1'b0; else trig0 = 1'b0;
    endtask

    task automatic irq0_period(output int per);
        int g;
        per = -1;
        g = 0;
        while (!irq0 && g < 5000) begin @(negedge clk); g++; end
        if (g < 5000) begin
            per = 0;
            do begin @(negedge clk); per++; end while (!irq0 && per < 5000);
        end
    endtask

    initial begin
        #1520000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, v2, b0, b1, per, t_cap, t_irq, hi, k0, k1;
        void'($urandom(32'd20240));
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // reset state
        rd(A_CTRL, v); chk(v == 0, "R1", "ctrl after reset", v, 0);
        rd(A_CNT, v);  chk(v == 0, "R1", "count after reset", v, 0);
        chk(!irq0 && !irq1 && !tmr_out && !ovf_flag, "R1", "outputs after reset",
            int'({irq0, irq1, tmr_out, ovf_flag}), 0);

        // stopped: edges and one-shot ignored
        wr(A_CR0, 16'h1234); wr(A_CR1, 16'h5678);
        wr(A_CTRL, mk(0, 0, 0, 0, 1, 1, 1, 1));
        k0 = n_irq0; k1 = n_irq1;
        pulse(0, 20); pulse(1, 20); cyc(20);
        rd(A_CR0, v); chk(v == 16'h1234, "R1", "CR0 while stopped", v, 16'h1234);
        rd(A_CR1, v); chk(v == 16'h5678, "R1", "CR1 while stopped", v, 16'h5678);
        rd(A_CNT, v); chk(v == 0, "R1", "count while stopped", v, 0);
        chk(n_irq0 == k0 && n_irq1 == k1, "R1", "irq while stopped", n_irq0 + n_irq1 - k0 - k1, 0);
        wr(A_CR0, 16'd30); wr(A_CR1, 16'd10);
        wr(A_STAT, 16'h2);
        wr(A_CTRL, mk(1, 0, 0, 0, 0, 0, 0, 0));
        hi = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (tmr_out) hi++; end
        chk(hi == 0, "R1", "one-shot request while stopped", hi, 0);

        // clear-on-match period under random compare values and prescales
        for (int it = 0; it < 6; it++) begin
            int c, s;
            c = int'($urandom_range(40, 3));
            s = int'($urandom_range(3, 0));
            wr(A_CTRL, 16'd0);
            wr(A_CR0, 16'(c));
            wr(A_CTRL, mk(1, 1, s, 0, 0, 0, 0, 0));
            irq0_period(per);
            chk(per == exp_period(c, s), "R5", "irq0 period (R2 prescale)", per, exp_period(c, s));
        end

        // compare match in free mode
        wr(A_CTRL, 16'd0); wr(A_CR0, 16'd50); wr(A_CR1, 16'd70);
        k0 = n_irq0; k1 = n_irq1;
        wr(A_CTRL, mk(1, 0, 0, 0, 0, 0, 0, 0));
        cyc(40);
        chk(n_irq0 == k0, "R4", "irq0 before match", n_irq0 - k0, 0);
        cyc(60);
        chk(n_irq0 - k0 == 1, "R4", "irq0 pulses", n_irq0 - k0, 1);
        chk(n_irq1 - k1 == 1, "R4", "irq1 pulses", n_irq1 - k1, 1);

        // capture into CR0 on trig1 rising, irq delay at divide-by-4
        wr(A_CR0, 16'h1234);
        cfg(mk(1, 0, 2, 0, 0, 1, 1, 0));
        cyc(20);
        rd(A_CR0, b0);
        trig1 = 1'b1;
        t_cap = -1; t_irq = -1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk); #1;
            if (t_cap < 0 && int'(rdata) != b0) t_cap = i;
            if (t_irq < 0 && irq0) t_irq = i;
        end
        trig1 = 1'b0;
        chk(t_cap >= 0, "R7", "CR0 captured on trig1 rise", t_cap, 0);
        chk(t_irq - t_cap == 3, "R11", "capture irq delay", t_irq - t_cap, 3);
        cyc(30);

        // edge select none: no capture
        wr(A_CTRL, mk(1, 0, 2, 0, 0, 0, 1, 0));
        rd(A_CR0, b0); k0 = n_irq0;
        pulse(1, 40); cyc(40);
        rd(A_CR0, v);
        chk(v == b0 && n_irq0 == k0, "R7", "edge select none", v, b0);

        // falling edge select: nothing on rise, capture on fall
        wr(A_CTRL, mk(1, 0, 2, 0, 0, 2, 1, 0));
        rd(A_CR0, b0);
        @(negedge clk); trig1 = 1'b1; cyc(40);
        rd(A_CR0, v); chk(v == b0, "R7", "falling select ignores rise", v, b0);
        trig1 = 1'b0; cyc(40);
        rd(A_CR0, v); chk(v != b0, "R7", "falling select captures fall", v, b0 + 1);

        // two-sample filter at divide-by-8
        cfg(mk(1, 0, 3, 0, 0, 1, 1, 0));
        cyc(20);
        rd(A_CR0, b0); k0 = n_irq0;
        pulse(1, 6); cyc(60);
        rd(A_CR0, v);
        chk(v == b0 && n_irq0 == k0, "R10", "short pulse rejected", v, b0);
        pulse(1, 24); cyc(60);
        rd(A_CR0, v); chk(v != b0, "R10", "long pulse captured", v, b0 + 1);

        // counter reads do not capture
        wr(A_CR1, 16'h0BEE);
        cfg(mk(1, 0, 0, 0, 1, 0, 0, 1));
        for (int i = 0; i < 20; i++) rd(A_CNT, v);
        rd(A_CR1, v); chk(v == 16'h0BEE, "R8", "CR1 after counter reads", v, 16'h0BEE);

        // trigger 0 capture blocked for both edges and external clock
        cfg(mk(1, 0, 0, 0, 3, 0, 0, 1));
        k1 = n_irq1;
        pulse(0, 10); cyc(10); pulse(0, 10); cyc(10);
        rd(A_CR1, v); chk(v == 16'h0BEE, "R9", "CR1 with both-edge select", v, 16'h0BEE);
        chk(n_irq1 == k1, "R9", "irq1 with both-edge select", n_irq1 - k1, 0);
        cfg(mk(1, 0, 0, 1, 1, 0, 0, 1));
        for (int i = 0; i < 5; i++) begin pulse(0, 6); cyc(6); end
        cyc(10);
        rd(A_CR1, v); chk(v == 16'h0BEE, "R9", "CR1 with external count", v, 16'h0BEE);
        rd(A_CNT, v); chk(v == 5, "R2", "external edge count", v, 5);

        // clear on trigger 0 edge
        cfg(mk(1, 2, 0, 0, 1, 0, 0, 0));
        cyc(200);
        rd(A_CNT, v);
        pulse(0, 12);
        rd(A_CNT, v2);
        chk(v > 150 && v2 < 14, "R6", "count after clear edge", v2, 0);

        // one-shot width, retrigger ignored, overflow over a full wrap
        wr(A_CTRL, 16'd0);
        wr(A_STAT, 16'h1);
        wr(A_CR0, 16'd30); wr(A_CR1, 16'd10);
        wr(A_CTRL, mk(1, 0, 0, 0, 0, 0, 0, 0));
        wr(A_STAT, 16'h2);
        hi = 0; t_cap = 0;
        while (!tmr_out && t_cap < 200) begin @(negedge clk); t_cap++; end
        hi = 1;
        wr(A_STAT, 16'h2);
        hi += 2;
        #1;
        while (tmr_out && hi < 200) begin @(negedge clk); #1; if (tmr_out) hi++; end
        chk(hi == 20, "R12", "one-shot width", hi, 20);
        rd(A_STAT, v); chk(v == 0, "R3", "no overflow before wrap", v, 0);
        hi = 0;
        for (int i = 0; i < 66000; i++) begin @(negedge clk); if (tmr_out) hi++; end
        chk(hi == 0, "R12", "retrigger during pulse ignored", hi, 0);
        rd(A_STAT, v); chk(v == 1, "R3", "overflow after wrap", v, 1);
        wr(A_STAT, 16'h1);
        rd(A_STAT, v); chk(v == 0, "R3", "overflow cleared", v, 0);

        // one-shot ignored in clear-on-match mode
        wr(A_CTRL, 16'd0); wr(A_CR0, 16'd100); wr(A_CR1, 16'd10);
        wr(A_CTRL, mk(1, 1, 0, 0, 0, 0, 0, 0));
        wr(A_STAT, 16'h2);
        hi = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (tmr_out) hi++; end
        chk(hi == 0, "R13", "one-shot in clear-on-match", hi, 0);

        // stop returns counter to zero
        wr(A_CTRL, 16'd0);
        rd(A_CNT, v); chk(v == 0, "R1", "count after stop", v, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule